// File: doc/BRIEF.md
# Miss Status Holding Registers

This block keeps track of cache misses that are still outstanding in a non-blocking data cache. When the cache misses, it offers the miss here. The block then either opens a fresh entry, or joins the miss to an entry already waiting on the same block. An entry holds the block address, the cache frame reserved to receive the fill, and up to two requester tags naming the loads that wait on it. The cache keeps serving hits while entries are live, and it can keep offering new misses until capacity or a frame clash stops it.

A lookup port answers, in the same cycle, whether a block address already has a miss in flight. The cache uses this to avoid sending a second request to the lower level for the same block. Fills return in any order, each naming the entry index it answers. In that same cycle the block presents the reserved frame, the block address and the waiting tags on its completion output, and the entry becomes free at the clock edge that ends the cycle.

Top module: `mshr_file`

## Requirements
- R1: After reset no entry is live: `lookup_hit` is 0 for any address and a fill to any index raises no completion.
- R2: A miss to an address held by no live entry, whose frame is reserved by no live entry, is accepted into the lowest-numbered free entry. `alloc_accept`=1, `alloc_merged`=0 and `alloc_idx` names that entry. A frame freed by a completed fill may be claimed again.
- R3: `lookup_hit` is 1 in the same cycle, and `lookup_idx` names the entry, exactly when a live entry holds `lookup_addr`. A lookup never changes any entry.
- R4: A miss to an address held by a live entry that has one tag is accepted with `alloc_merged`=1 and `alloc_idx` set to that entry. No new entry opens. The later fill reports both tags, the first in `cmp_tag0` and the merged one in `cmp_tag1`, with `cmp_tag1_valid`=1.
- R5: A miss to an address held by a live entry that already has two tags is refused with `alloc_stall`=1 and leaves the entry unchanged.
- R6: A miss to a new address whose frame equals the frame of any live entry is refused with `alloc_conflict`=1, `alloc_stall`=0, and no entry opens.
- R7: When all entries are live, a miss to a new, non-clashing address is refused with `alloc_stall`=1 and no entry opens.
- R8: A fill to a live entry gives `cmp_valid`=1 in the same cycle, with that entry's address, frame and tags. Fills may target entries in any order, and the entry is free from the next cycle.
- R9: A fill naming an entry that is not live gives `cmp_valid`=0 and changes nothing.
- R10: A miss whose address matches the entry being filled in the same cycle is refused with `alloc_stall`=1. The fill still completes.
- R11: A new allocation and a fill to another entry in the same cycle both take effect. The allocation sees the entries as they were before that cycle's fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| alloc_valid | input | 1 | A cache miss is offered this cycle |
| alloc_addr | input | ADDR_W | Block address of the miss |
| alloc_frame | input | FRAME_W | Cache frame chosen to receive the fill |
| alloc_tag | input | TAG_W | Tag of the requesting load |
| alloc_accept | output | 1 | Miss taken (new entry or merge) |
| alloc_merged | output | 1 | Miss joined an existing entry |
| alloc_stall | output | 1 | Miss refused for lack of room |
| alloc_conflict | output | 1 | Miss refused because its frame is already reserved |
| alloc_idx | output | IDX_W | Entry that took the miss |
| lookup_addr | input | ADDR_W | Block address to search |
| lookup_hit | output | 1 | A live entry holds lookup_addr |
| lookup_idx | output | IDX_W | Index of that entry |
| fill_valid | input | 1 | A fill returns this cycle |
| fill_idx | input | IDX_W | Entry the fill answers |
| cmp_valid | output | 1 | Completion of a live entry |
| cmp_addr | output | ADDR_W | Block address of the completed entry |
| cmp_frame | output | FRAME_W | Frame to write the fill into |
| cmp_tag0 | output | TAG_W | First requester tag |
| cmp_tag1 | output | TAG_W | Merged requester tag |
| cmp_tag1_valid | output | 1 | cmp_tag1 holds a real requester |

## Verification
The assertions check several invariants on every cycle: no two live entries share a frame (R6) or a block address (R4), a refused miss with no fill leaves the set of live entries unchanged (R5, R7), a completed entry is gone the next cycle (R8), and each entry is set only when free and merged only while it has one tag. The values on the port side can only be shown by the bench's scenarios. These are which entry index is picked, the tags and frame a completion reports after out-of-order fills, and the collision rules when an allocation and a fill meet in one cycle (R10, R11).

// File: rtl/mshr_pkg.sv
package mshr_pkg;

  // Requesters one entry can hold (the primary plus one merged load)
  localparam int unsigned MAX_TAGS = 2;

  typedef enum logic [2:0] {
    ALLOC_NONE     = 3'd0,
    ALLOC_NEW      = 3'd1,
    ALLOC_MERGE    = 3'd2,
    ALLOC_STALL    = 3'd3,
    ALLOC_CONFLICT = 3'd4
  } alloc_outcome_e;

endpackage

// File: rtl/mshr_pick_first.sv
module mshr_pick_first #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  // Lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/mshr_entry.sv
module mshr_entry #(
  parameter int unsigned ADDR_W  = 26,
  parameter int unsigned FRAME_W = 8,
  parameter int unsigned TAG_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_i,
  input  logic               merge_i,
  input  logic               clear_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [TAG_W-1:0]   tag_i,
  output logic               valid_o,
  output logic               two_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [TAG_W-1:0]   tag0_o,
  output logic [TAG_W-1:0]   tag1_o
);

  logic               valid_q, valid_d;
  logic               two_q, two_d;
  logic [ADDR_W-1:0]  addr_q;
  logic [FRAME_W-1:0] frame_q;
  logic [TAG_W-1:0]   tag0_q, tag1_q;
  logic               main_en, tag1_en;

  // Next-state for the control bits
  always_comb begin
    valid_d = valid_q;
    two_d   = two_q;
    if (clear_i) begin
      valid_d = 1'b0;
      two_d   = 1'b0;
    end else if (set_i) begin
      valid_d = 1'b1;
      two_d   = 1'b0;
    end else if (merge_i) begin
      two_d   = 1'b1;
    end
  end

  assign main_en = set_i;
  assign tag1_en = merge_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      two_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      two_q   <= two_d;
    end
  end

  // Payload registers: enabled loads, no reset needed
  always_ff @(posedge clk) begin
    if (main_en) begin
      addr_q  <= addr_i;
      frame_q <= frame_i;
      tag0_q  <= tag_i;
    end
    if (tag1_en) begin
      tag1_q <= tag_i;
    end
  end

  assign valid_o = valid_q;
  assign two_o   = two_q;
  assign addr_o  = addr_q;
  assign frame_o = frame_q;
  assign tag0_o  = tag0_q;
  assign tag1_o  = tag1_q;

  // R2
  set_only_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |-> !valid_q);

  // R4
  merge_only_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    merge_i |-> (valid_q && !two_q));

  // R5
  two_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (two_q && !clear_i) |=> two_q);

  // R9
  clear_only_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |-> valid_q);

endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned ADDR_W  = 26,
  parameter int unsigned FRAME_W = 8,
  parameter int unsigned TAG_W   = 6,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  input  logic [ADDR_W-1:0]  alloc_addr,
  input  logic [FRAME_W-1:0] alloc_frame,
  input  logic [TAG_W-1:0]   alloc_tag,
  output logic               alloc_accept,
  output logic               alloc_merged,
  output logic               alloc_stall,
  output logic               alloc_conflict,
  output logic [IDX_W-1:0]   alloc_idx,
  input  logic [ADDR_W-1:0]  lookup_addr,
  output logic               lookup_hit,
  output logic [IDX_W-1:0]   lookup_idx,
  input  logic               fill_valid,
  input  logic [IDX_W-1:0]   fill_idx,
  output logic               cmp_valid,
  output logic [ADDR_W-1:0]  cmp_addr,
  output logic [FRAME_W-1:0] cmp_frame,
  output logic [TAG_W-1:0]   cmp_tag0,
  output logic [TAG_W-1:0]   cmp_tag1,
  output logic               cmp_tag1_valid
);

  logic [ENTRIES-1:0] ent_valid, ent_two;
  logic [ADDR_W-1:0]  ent_addr  [ENTRIES];
  logic [FRAME_W-1:0] ent_frame [ENTRIES];
  logic [TAG_W-1:0]   ent_tag0  [ENTRIES];
  logic [TAG_W-1:0]   ent_tag1  [ENTRIES];

  logic [ENTRIES-1:0] addr_match, frame_match, lk_match, free_vec;
  logic [ENTRIES-1:0] set_vec, merge_vec, clear_vec;
  logic               addr_any, lk_any, free_any;
  logic [IDX_W-1:0]   match_idx, free_idx, lk_idx;
  logic               fill_live;
  alloc_outcome_e     outcome;

  // Entry storage
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    mshr_entry #(
      .ADDR_W (ADDR_W),
      .FRAME_W(FRAME_W),
      .TAG_W  (TAG_W)
    ) ent_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec[g]),
      .merge_i(merge_vec[g]),
      .clear_i(clear_vec[g]),
      .addr_i (alloc_addr),
      .frame_i(alloc_frame),
      .tag_i  (alloc_tag),
      .valid_o(ent_valid[g]),
      .two_o  (ent_two[g]),
      .addr_o (ent_addr[g]),
      .frame_o(ent_frame[g]),
      .tag0_o (ent_tag0[g]),
      .tag1_o (ent_tag1[g])
    );

    assign addr_match[g]  = ent_valid[g] && (ent_addr[g] == alloc_addr);
    assign frame_match[g] = ent_valid[g] && (ent_frame[g] == alloc_frame);
    assign lk_match[g]    = ent_valid[g] && (ent_addr[g] == lookup_addr);
    assign free_vec[g]    = !ent_valid[g];

    assign set_vec[g]   = (outcome == ALLOC_NEW)   && (free_idx  == IDX_W'(g));
    assign merge_vec[g] = (outcome == ALLOC_MERGE) && (match_idx == IDX_W'(g));
    assign clear_vec[g] = fill_live && (fill_idx == IDX_W'(g));
  end

  // Searches over live entries
  mshr_pick_first #(.N(ENTRIES), .IDX_W(IDX_W)) addr_pick_i (
    .req_i(addr_match), .any_o(addr_any), .idx_o(match_idx));
  mshr_pick_first #(.N(ENTRIES), .IDX_W(IDX_W)) free_pick_i (
    .req_i(free_vec),   .any_o(free_any), .idx_o(free_idx));
  mshr_pick_first #(.N(ENTRIES), .IDX_W(IDX_W)) look_pick_i (
    .req_i(lk_match),   .any_o(lk_any),   .idx_o(lk_idx));

  assign fill_live = fill_valid && ent_valid[fill_idx];

  // Allocation decision: address match first, then frame clash, then room
  always_comb begin
    outcome = ALLOC_NONE;
    if (alloc_valid) begin
      if (addr_any) begin
        if (ent_two[match_idx] || (fill_live && (fill_idx == match_idx)))
          outcome = ALLOC_STALL;
        else
          outcome = ALLOC_MERGE;
      end else if (|frame_match) begin
        outcome = ALLOC_CONFLICT;
      end else if (!free_any) begin
        outcome = ALLOC_STALL;
      end else begin
        outcome = ALLOC_NEW;
      end
    end
  end

  assign alloc_accept   = (outcome == ALLOC_NEW) || (outcome == ALLOC_MERGE);
  assign alloc_merged   = (outcome == ALLOC_MERGE);
  assign alloc_stall    = (outcome == ALLOC_STALL);
  assign alloc_conflict = (outcome == ALLOC_CONFLICT);
  assign alloc_idx      = (outcome == ALLOC_MERGE) ? match_idx : free_idx;

  assign lookup_hit = lk_any;
  assign lookup_idx = lk_idx;

  // Completion, same cycle as the fill
  assign cmp_valid      = fill_live;
  assign cmp_addr       = fill_live ? ent_addr[fill_idx]  : '0;
  assign cmp_frame      = fill_live ? ent_frame[fill_idx] : '0;
  assign cmp_tag0       = fill_live ? ent_tag0[fill_idx]  : '0;
  assign cmp_tag1       = (fill_live && ent_two[fill_idx]) ? ent_tag1[fill_idx] : '0;
  assign cmp_tag1_valid = fill_live && ent_two[fill_idx];

  // Pairwise invariants over live entries
  for (genvar i = 0; i < ENTRIES; i++) begin : g_pa
    for (genvar j = i + 1; j < ENTRIES; j++) begin : g_pb
      // R6
      frame_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_valid[i] && ent_valid[j]) |-> (ent_frame[i] != ent_frame[j]));
      // R4
      addr_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_valid[i] && ent_valid[j]) |-> (ent_addr[i] != ent_addr[j]));
    end
  end

  // R5
  refused_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_accept && !fill_valid) |=> $stable(ent_valid));

  // R8
  freed_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> !ent_valid[$past(fill_idx)]);

  // R2
  new_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_accept && !alloc_merged && !cmp_valid) |=>
      ($countones(ent_valid) == $countones($past(ent_valid)) + 1));

  // R7
  verdict_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({alloc_accept, alloc_stall, alloc_conflict}));

endmodule

// File: tb/mshr_file_tb_top.sv
module mshr_file_tb_top;

  localparam int unsigned ENTRIES = 4;
  localparam int unsigned ADDR_W  = 26;
  localparam int unsigned FRAME_W = 8;
  localparam int unsigned TAG_W   = 6;
  localparam int unsigned IDX_W   = 2;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               alloc_valid;
  logic [ADDR_W-1:0]  alloc_addr;
  logic [FRAME_W-1:0] alloc_frame;
  logic [TAG_W-1:0]   alloc_tag;
  logic               alloc_accept, alloc_merged, alloc_stall, alloc_conflict;
  logic [IDX_W-1:0]   alloc_idx;
  logic [ADDR_W-1:0]  lookup_addr;
  logic               lookup_hit;
  logic [IDX_W-1:0]   lookup_idx;
  logic               fill_valid;
  logic [IDX_W-1:0]   fill_idx;
  logic               cmp_valid;
  logic [ADDR_W-1:0]  cmp_addr;
  logic [FRAME_W-1:0] cmp_frame;
  logic [TAG_W-1:0]   cmp_tag0, cmp_tag1;
  logic               cmp_tag1_valid;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  mshr_file #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .FRAME_W(FRAME_W), .TAG_W(TAG_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_addr(alloc_addr),
    .alloc_frame(alloc_frame), .alloc_tag(alloc_tag),
    .alloc_accept(alloc_accept), .alloc_merged(alloc_merged),
    .alloc_stall(alloc_stall), .alloc_conflict(alloc_conflict),
    .alloc_idx(alloc_idx),
    .lookup_addr(lookup_addr), .lookup_hit(lookup_hit), .lookup_idx(lookup_idx),
    .fill_valid(fill_valid), .fill_idx(fill_idx),
    .cmp_valid(cmp_valid), .cmp_addr(cmp_addr), .cmp_frame(cmp_frame),
    .cmp_tag0(cmp_tag0), .cmp_tag1(cmp_tag1), .cmp_tag1_valid(cmp_tag1_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle's inputs at the falling edge; outputs are sampled 2 ns later
  task automatic drive(input logic av, input logic [ADDR_W-1:0] a,
                       input logic [FRAME_W-1:0] f, input logic [TAG_W-1:0] t,
                       input logic [ADDR_W-1:0] la,
                       input logic fv, input logic [IDX_W-1:0] fi);
    @(negedge clk);
    alloc_valid = av; alloc_addr = a; alloc_frame = f; alloc_tag = t;
    lookup_addr = la; fill_valid = fv; fill_idx = fi;
    #2;
  endtask

  task automatic t_reset;
    alloc_valid = 0; alloc_addr = '0; alloc_frame = '0; alloc_tag = '0;
    lookup_addr = '0; fill_valid = 0; fill_idx = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    drive(0, 0, 0, 0, 26'h100, 1, 2'd0);
    check("R1 lookup_hit", 32'(lookup_hit), 0);
    check("R1 cmp_valid", 32'(cmp_valid), 0);
    drive(0, 0, 0, 0, 26'h0, 1, 2'd3);
    check("R9 cmp_valid on idle idx3", 32'(cmp_valid), 0);
  endtask

  task automatic t_alloc;
    drive(1, 26'h100, 8'd3, 6'd5, 26'h0, 0, 0);
    check("R2 accept A", 32'(alloc_accept), 1);
    check("R2 merged A", 32'(alloc_merged), 0);
    check("R2 idx A", 32'(alloc_idx), 0);
    drive(1, 26'h200, 8'd7, 6'd9, 26'h100, 0, 0);
    check("R2 idx B", 32'(alloc_idx), 1);
    check("R3 lookup A hit", 32'(lookup_hit), 1);
    check("R3 lookup A idx", 32'(lookup_idx), 0);
    drive(0, 0, 0, 0, 26'h200, 0, 0);
    check("R3 lookup B idx", 32'(lookup_idx), 1);
    drive(0, 0, 0, 0, 26'h300, 0, 0);
    check("R3 lookup absent", 32'(lookup_hit), 0);
  endtask

  task automatic t_merge;
    drive(1, 26'h100, 8'd9, 6'd11, 26'h0, 0, 0);
    check("R4 merge accept", 32'(alloc_accept), 1);
    check("R4 merge flag", 32'(alloc_merged), 1);
    check("R4 merge idx", 32'(alloc_idx), 0);
    drive(1, 26'h100, 8'd9, 6'd12, 26'h0, 0, 0);
    check("R5 third tag stall", 32'(alloc_stall), 1);
    check("R5 third tag accept", 32'(alloc_accept), 0);
  endtask

  task automatic t_conflict;
    drive(1, 26'h300, 8'd7, 6'd1, 26'h0, 0, 0);
    check("R6 conflict", 32'(alloc_conflict), 1);
    check("R6 no stall", 32'(alloc_stall), 0);
    check("R6 no accept", 32'(alloc_accept), 0);
    drive(0, 0, 0, 0, 26'h300, 0, 0);
    check("R6 nothing opened", 32'(lookup_hit), 0);
  endtask

  task automatic t_full;
    drive(1, 26'h300, 8'd1, 6'h21, 26'h0, 0, 0);
    check("R2 idx C", 32'(alloc_idx), 2);
    drive(1, 26'h400, 8'd2, 6'h22, 26'h0, 0, 0);
    check("R2 idx D", 32'(alloc_idx), 3);
    drive(1, 26'h500, 8'd4, 6'h23, 26'h0, 0, 0);
    check("R7 full stall", 32'(alloc_stall), 1);
    check("R7 full accept", 32'(alloc_accept), 0);
    drive(0, 0, 0, 0, 26'h500, 0, 0);
    check("R7 nothing opened", 32'(lookup_hit), 0);
  endtask

  task automatic t_fill_ooo;
    drive(0, 0, 0, 0, 26'h300, 1, 2'd2);
    check("R8 cmp C valid", 32'(cmp_valid), 1);
    check("R8 cmp C addr", 32'(cmp_addr), 32'h300);
    check("R8 cmp C frame", 32'(cmp_frame), 1);
    check("R8 cmp C tag0", 32'(cmp_tag0), 32'h21);
    check("R8 cmp C one tag", 32'(cmp_tag1_valid), 0);
    check("R8 C still live in fill cycle", 32'(lookup_hit), 1);
    drive(0, 0, 0, 0, 26'h300, 1, 2'd0);
    check("R8 C freed", 32'(lookup_hit), 0);
    check("R4 cmp A frame", 32'(cmp_frame), 3);
    check("R4 cmp A tag0", 32'(cmp_tag0), 5);
    check("R4 cmp A tag1", 32'(cmp_tag1), 11);
    check("R4 cmp A two tags", 32'(cmp_tag1_valid), 1);
    drive(0, 0, 0, 0, 26'h0, 1, 2'd0);
    check("R9 refill freed idx0", 32'(cmp_valid), 0);
  endtask

  task automatic t_same_cycle;
    drive(1, 26'h200, 8'd7, 6'd13, 26'h0, 1, 2'd1);
    check("R10 stall on filling addr", 32'(alloc_stall), 1);
    check("R10 fill completes", 32'(cmp_valid), 1);
    check("R10 fill frame", 32'(cmp_frame), 7);
    drive(1, 26'h500, 8'd4, 6'h23, 26'h0, 1, 2'd3);
    check("R11 accept E", 32'(alloc_accept), 1);
    check("R11 idx E", 32'(alloc_idx), 0);
    check("R11 cmp D addr", 32'(cmp_addr), 32'h400);
    check("R11 cmp D tag0", 32'(cmp_tag0), 32'h22);
    drive(0, 0, 0, 0, 26'h500, 0, 0);
    check("R11 E live", 32'(lookup_hit), 1);
    check("R11 E idx", 32'(lookup_idx), 0);
    drive(0, 0, 0, 0, 26'h400, 0, 0);
    check("R11 D freed", 32'(lookup_hit), 0);
    drive(1, 26'h600, 8'd3, 6'd2, 26'h0, 0, 0);
    check("R2 freed frame reused", 32'(alloc_accept), 1);
    check("R2 reuse idx", 32'(alloc_idx), 1);
    drive(0, 0, 0, 0, 26'h0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_alloc();
    t_merge();
    t_conflict();
    t_full();
    t_fill_ooo();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule